// File: doc/BRIEF.md
# Sleep and Wake Sequencer

This block decides when a motor bridge driver may run. It watches a synchronized active-low sleep request and a supply-good flag. While the request is low the driver is held asleep: the active flag stays low, so the bridge stays off, and the supply flag is ignored. When the request goes high and the supply is good, the block counts a wake delay and then raises the active flag. When the request goes low again, the block counts an entry delay and then drops the active flag.

Two single-cycle pulses go to the neighbouring blocks. The configuration strobe tells the mode decoders to capture their strap settings, and it fires only on the cycle the driver becomes active. The fault-clear pulse fires on the cycle the driver falls asleep. It is the one way, short of removing power, to clear an overcurrent fault that has latched the outputs off. Both delays are parameters counted in clock cycles.

Top module: `sleep_wake_seq`

## Requirements
- R1: After reset the block is asleep, and `active`, `cfgLatch` and `faultClear` are all 0.
- R2: While asleep with `sleepReqN` low, no value or change of `supplyGood` affects any output.
- R3: When asleep with `sleepReqN` and `supplyGood` both high at a clock edge, `active` goes to 1 exactly WAKE_CYCLES+1 edges later, counting that edge as the first, provided both inputs stay high.
- R4: If `supplyGood` is low at an edge during the wake delay, the delay restarts: `active` goes to 1 exactly WAKE_CYCLES edges after that edge, provided both inputs then stay high.
- R5: If `sleepReqN` is low at an edge during the wake delay, the block returns to sleep without raising `active` or `faultClear`, and a later wake takes the full delay of R3.
- R6: `cfgLatch` is a one-cycle pulse that is 1 in exactly the first cycle in which `active` is 1 after being 0, and it is 0 in every other cycle.
- R7: From active, if `sleepReqN` is low at SLEEP_CYCLES+1 consecutive edges, `active` drops to 0 after the last of those edges.
- R8: If `sleepReqN` is high again at any of those SLEEP_CYCLES+1 edges, `active` stays 1 throughout and neither pulse fires.
- R9: `faultClear` is a one-cycle pulse that is 1 in exactly the first cycle in which `active` is 0 after being 1, and it is 0 in every other cycle.
- R10: While active with `sleepReqN` high, `supplyGood` does not affect `active`. Undervoltage is handled by the fault logic, not by this block.
- R11: The internal state is one-hot with exactly one of four states set (asleep, waking, active, entering sleep).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| sleepReqN | input | 1 | Synchronized sleep request, low requests sleep |
| supplyGood | input | 1 | Supply is above its undervoltage threshold |
| active | output | 1 | Driver is active, and the bridge may be driven |
| cfgLatch | output | 1 | One-cycle strobe to capture the mode configuration |
| faultClear | output | 1 | One-cycle pulse that clears latched faults on sleep entry |

## Verification
The hardest case to reach is a supply dip that lands on the very last cycle of the wake delay. At that edge the timer has reached its limit, so the restart must win over the transition to active. The bench reaches it by sweeping a single low cycle of `supplyGood` across every edge of the wake delay, from the first to the last. It expects activation exactly WAKE_CYCLES edges after the dip. In the same way, a sleep request is held low for every length from 1 to SLEEP_CYCLES, which proves the abort still wins on the final counting edge.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;

  // one-hot power states
  typedef enum logic [3:0] {
    ST_SLEEP  = 4'b0001,
    ST_WAKING = 4'b0010,
    ST_ACTIVE = 4'b0100,
    ST_ENTER  = 4'b1000
  } pwrState_t;

  // strobes from the control to the delay timer
  typedef struct packed {
    logic clear;    // force the count to zero
    logic count;    // advance the count by one
    logic selWake;  // compare against the wake limit (else sleep limit)
  } timerCtl_t;

endpackage

// File: rtl/sleep_wake_timer.sv
module sleep_wake_timer
  import sleep_wake_pkg::*;
#(
  parameter int WAKE_CYCLES  = 8,
  parameter int SLEEP_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCtl_t ctl,
  output logic      done
);

  localparam int MAX_CYCLES = (WAKE_CYCLES > SLEEP_CYCLES) ? WAKE_CYCLES : SLEEP_CYCLES;
  localparam int CW = (MAX_CYCLES > 1) ? $clog2(MAX_CYCLES) : 1;
  localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYCLES - 1);
  localparam logic [CW-1:0] SLEEP_LAST = CW'(SLEEP_CYCLES - 1);

  logic [CW-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      cntQ <= '0;
    end else if (ctl.count) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign done = (cntQ == (ctl.selWake ? WAKE_LAST : SLEEP_LAST));

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import sleep_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepReqN,
  input  logic      supplyGood,
  input  logic      timerDone,
  output timerCtl_t timerCtl,
  output logic [3:0] stateVec,
  output logic      active,
  output logic      cfgLatch,
  output logic      faultClear
);

  pwrState_t stateQ, stateD;
  logic cfgLatchQ, faultClearQ;

  always_comb begin
    stateD   = stateQ;
    timerCtl = '{clear: 1'b1, count: 1'b0, selWake: 1'b1};
    case (stateQ)
      ST_SLEEP: begin
        if (sleepReqN && supplyGood) stateD = ST_WAKING;
      end
      ST_WAKING: begin
        if (!sleepReqN) begin
          stateD = ST_SLEEP;
        end else if (!supplyGood) begin
          timerCtl.clear = 1'b1;  // restart the wake delay
        end else if (timerDone) begin
          stateD = ST_ACTIVE;
        end else begin
          timerCtl.clear = 1'b0;
          timerCtl.count = 1'b1;
        end
      end
      ST_ACTIVE: begin
        timerCtl.selWake = 1'b0;
        if (!sleepReqN) stateD = ST_ENTER;
      end
      ST_ENTER: begin
        timerCtl.selWake = 1'b0;
        if (sleepReqN) begin
          stateD = ST_ACTIVE;
        end else if (timerDone) begin
          stateD = ST_SLEEP;
        end else begin
          timerCtl.clear = 1'b0;
          timerCtl.count = 1'b1;
        end
      end
      default: stateD = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ST_SLEEP;
      cfgLatchQ   <= 1'b0;
      faultClearQ <= 1'b0;
    end else begin
      stateQ      <= stateD;
      cfgLatchQ   <= (stateQ == ST_WAKING) && (stateD == ST_ACTIVE);
      faultClearQ <= (stateQ == ST_ENTER) && (stateD == ST_SLEEP);
    end
  end

  assign stateVec   = stateQ;
  assign active     = (stateQ == ST_ACTIVE) || (stateQ == ST_ENTER);
  assign cfgLatch   = cfgLatchQ;
  assign faultClear = faultClearQ;

endmodule

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq
  import sleep_wake_pkg::*;
#(
  parameter int WAKE_CYCLES  = 8,
  parameter int SLEEP_CYCLES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReqN,
  input  logic supplyGood,
  output logic active,
  output logic cfgLatch,
  output logic faultClear
);

  timerCtl_t  timerCtl;
  logic       timerDone;
  logic [3:0] stateVec;

  sleep_wake_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sleepReqN (sleepReqN),
    .supplyGood(supplyGood),
    .timerDone (timerDone),
    .timerCtl  (timerCtl),
    .stateVec  (stateVec),
    .active    (active),
    .cfgLatch  (cfgLatch),
    .faultClear(faultClear)
  );

  sleep_wake_timer #(
    .WAKE_CYCLES (WAKE_CYCLES),
    .SLEEP_CYCLES(SLEEP_CYCLES)
  ) u_timer (
    .clk (clk),
    .rstN(rstN),
    .ctl (timerCtl),
    .done(timerDone)
  );

endmodule

// File: rtl/sleep_wake_seq_chk.sv
module sleep_wake_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sleepReqN,
  input logic       supplyGood,
  input logic       active,
  input logic       cfgLatch,
  input logic       faultClear,
  input logic [3:0] stateVec
);

  // R2
  asleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepReqN && !active) |=> !active);

  // R3
  wake_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> ($past(sleepReqN) && $past(supplyGood)));

  // R6
  cfg_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> cfgLatch);

  // R6
  cfg_only_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgLatch |-> (active && !$past(active)));

  // R8
  stay_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && sleepReqN) |=> active);

  // R9
  clear_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> faultClear);

  // R9
  clear_only_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultClear |-> (!active && $past(active)));

  // R11
  state_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stateVec) == 1);

endmodule

bind sleep_wake_seq sleep_wake_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sleepReqN (sleepReqN),
  .supplyGood(supplyGood),
  .active    (active),
  .cfgLatch  (cfgLatch),
  .faultClear(faultClear),
  .stateVec  (stateVec)
);

// File: tb/sleep_wake_seq_tb.sv
module sleep_wake_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 6;
  localparam int S = 5;

  logic clk = 1'b0;
  logic rstN, sleepReqN, supplyGood;
  logic active, cfgLatch, faultClear;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_wake_seq #(.WAKE_CYCLES(W), .SLEEP_CYCLES(S)) u_dut (
    .clk(clk), .rstN(rstN), .sleepReqN(sleepReqN), .supplyGood(supplyGood),
    .active(active), .cfgLatch(cfgLatch), .faultClear(faultClear)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // compares {active, cfgLatch, faultClear}
  task automatic chk(input string req, input logic [2:0] exp);
    checks++;
    if ({active, cfgLatch, faultClear} !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, {active, cfgLatch, faultClear}, exp);
    end
  endtask

  task automatic goSleep();
    sleepReqN = 1'b0;
    for (int k = 1; k <= S + 2; k++) step();
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000 && !finished) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sleepReqN = 1'b1; supplyGood = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 3; k++) step();
    chk("R1 reset", 3'b000);
    sleepReqN = 1'b0;
    rstN = 1'b1;
    step();
    chk("R1 after reset", 3'b000);

    // R2: supply toggles while sleep requested
    for (int k = 0; k < 20; k++) begin
      supplyGood = (k % 3) != 0;
      step();
      chk("R2 ignore supply", 3'b000);
    end

    // R3 / R6: plain wake
    sleepReqN = 1'b1; supplyGood = 1'b1;
    for (int k = 1; k <= W + 3; k++) begin
      step();
      chk("R3 R6 wake", {k >= W + 1, k == W + 1, 1'b0});
    end

    // R10: supply drop while active
    supplyGood = 1'b0;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R10 supply while active", 3'b100);
    end
    supplyGood = 1'b1;

    // R8: aborted sleep entry for every length 1..S
    for (int a = 1; a <= S; a++) begin
      sleepReqN = 1'b0;
      for (int k = 0; k < a; k++) begin
        step();
        chk("R8 abort low", 3'b100);
      end
      sleepReqN = 1'b1;
      step();
      chk("R8 abort high", 3'b100);
      step();
      chk("R8 abort settle", 3'b100);
    end

    // R7 / R9: full sleep entry
    sleepReqN = 1'b0;
    for (int k = 1; k <= S + 3; k++) begin
      step();
      chk("R7 R9 sleep", {k < S + 1, 1'b0, k == S + 1});
    end

    // R4: one-cycle supply dip at every edge of the wake delay
    for (int g = 2; g <= W + 1; g++) begin
      sleepReqN = 1'b1;
      for (int k = 1; k <= g + W + 1; k++) begin
        supplyGood = (k != g);
        step();
        chk("R4 dip restart", {k >= g + W, k == g + W, 1'b0});
      end
      supplyGood = 1'b1;
      goSleep();
      chk("R4 back asleep", 3'b000);
    end

    // R5: wake aborted by sleep request, then full wake
    sleepReqN = 1'b1;
    for (int k = 0; k < 3; k++) step();
    sleepReqN = 1'b0;
    for (int k = 0; k < 2; k++) begin
      step();
      chk("R5 abort wake", 3'b000);
    end
    sleepReqN = 1'b1;
    for (int k = 1; k <= W + 1; k++) begin
      step();
      chk("R5 rewake full delay", {k >= W + 1, k == W + 1, 1'b0});
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule